// File: doc/BRIEF.md
# Bus Parity Checker and Error Reporter

This block watches a multiplexed 32-bit address/data bus with four byte-enable/command lines and one parity line, on behalf of a bus bridge. When the bridge masters a read, each completed data beat is checked for even parity one clock after the beat, when the parity line for that beat is valid. When the bridge masters a write, the remote agent's parity-error line (active low) is sampled instead. When the bridge is a possible target, the address phase is checked the same way.

Errors are reported in two ways. Some status flags are raised whenever bad parity is seen. Others are raised only when the software enable bits allow it. Drive requests go out for the parity-error and system-error lines, and a one-cycle error pulse goes toward the local bus for each bad beat. Software clears any status flag by writing a one to its position. The surrounding protocol sequencer supplies the phase strobes and the enable bits, and the register decoder supplies the clear strobe.

Top module: `bus_parity_monitor`

## Requirements
- R1: Parity is even. The 32 data lines, the 4 byte-enable lines and `par_i` together must hold an even number of ones. An odd count is a parity error.
- R2: A read beat is checked only when `mst_rd_i` is 1 and both `irdy_n_i` and `trdy_n_i` are 0 in the same cycle. The data and byte enables of that cycle are compared with `par_i` of the next cycle. In any other cycle the data lines raise no error.
- R3: `status_o[0]` (parity seen) sets on every bad read beat, whatever the value of `per_en_i`. A write or address error never sets it.
- R4: `status_o[1]` (data parity reported) sets only when `per_en_i` is 1 and either a bad read beat is found or `perr_n_i` is 0 while `mst_wr_i` is 1. `perr_n_i` low with `mst_wr_i` at 0 has no effect.
- R5: `perr_req_o` is a one-cycle pulse. It is high two clocks after a bad read beat when `per_en_i` is 1, and it stays 0 when `per_en_i` is 0.
- R6: `lb_err_o` is a one-cycle pulse per bad beat when both `per_en_i` and `lberr_en_i` are 1. For reads it is high two clocks after the beat. For writes it is high one clock after `perr_n_i` is sampled low.
- R7: `status_o[3]` (local error event) sets on the same errors as R4, whatever the value of `lberr_en_i`.
- R8: An address phase (`addr_phase_i` = 1) is checked against `par_i` of the next cycle. When it has bad parity and both `per_en_i` and `serr_en_i` are 1, `serr_req_o` pulses for one cycle two clocks after the phase and `status_o[2]` sets. Otherwise neither changes.
- R9: When `clr_we_i` is 1, each status bit whose `clr_mask_i` bit is 1 clears at the next edge. Mask bits of 0, or any mask while `clr_we_i` is 0, leave the status unchanged.
- R10: If a status bit is set by hardware and cleared by software at the same edge, it ends up 1.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Address/data lines |
| cbe_i | input | 4 | Command / byte-enable lines |
| par_i | input | 1 | Even parity for the previous cycle's lines |
| irdy_n_i | input | 1 | Initiator ready, active low |
| trdy_n_i | input | 1 | Target ready, active low |
| mst_rd_i | input | 1 | Bridge masters a read cycle |
| mst_wr_i | input | 1 | Bridge masters a write cycle; PERR# sampling window |
| addr_phase_i | input | 1 | Address phase with the bridge as possible target |
| perr_n_i | input | 1 | Remote parity-error line, active low |
| per_en_i | input | 1 | Parity error response enable |
| serr_en_i | input | 1 | System error signalling enable |
| lberr_en_i | input | 1 | Local-bus error pulse enable |
| clr_we_i | input | 1 | Status clear strobe |
| clr_mask_i | input | 4 | Write-one-to-clear mask, bit k clears status_o[k] |
| perr_req_o | output | 1 | Request to drive the parity-error line |
| serr_req_o | output | 1 | Request to drive the system-error line |
| lb_err_o | output | 1 | Per-beat error pulse toward the local bus |
| status_o | output | 4 | Sticky flags: [0] parity seen, [1] data parity reported, [2] system error signalled, [3] local error event |

## Verification
Read and address phases get a single one that walks across all 36 checked lines, with parity driven both correct and flipped. Each case runs under every combination of the enable bits. This separates the unconditional flag from the gated flags, and shows that every line reaches the parity reduction. Handshakes with only one ready line low show that incomplete beats are never checked. A back-to-back pair of beats, one bad and one good, checks the alignment of each beat with its own parity. Write sampling, stray PERR# outside writes, masked clears and a clear that lands on the same edge as a set cover the error-line paths and the clear rules.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
   localparam int STAT_W      = 4;
   localparam int ST_PAR_SEEN = 0;
   localparam int ST_DPE_RPT  = 1;
   localparam int ST_SERR     = 2;
   localparam int ST_LB_EVT   = 3;
   typedef logic [STAT_W-1:0] stat_vec_t;
endpackage

// File: rtl/bpm_xor_reduce.sv
module bpm_xor_reduce #(
   parameter int W    = 36,
   parameter bit TREE = 1'b1
) (
   input  logic [W-1:0] vec_i,
   output logic         odd_o
);
   localparam int LV = (W > 1) ? $clog2(W) : 1;
   localparam int P  = 1 << LV;

   generate
      if (W < 2) begin : g_bad_w
         $error("bpm_xor_reduce: W must be at least 2");
      end
      if (TREE) begin : g_tree
         // balanced pairwise reduction, zero padded to a power of two
         logic [P-1:0] lvl;
         always_comb begin
            lvl = '0;
            lvl[W-1:0] = vec_i;
            for (int s = P / 2; s >= 1; s = s / 2) begin
               for (int i = 0; i < s; i++) begin
                  lvl[i] = lvl[2*i] ^ lvl[2*i+1];
               end
            end
            odd_o = lvl[0];
         end
      end else begin : g_flat
         assign odd_o = ^vec_i;
      end
   endgenerate
endmodule

// File: rtl/bpm_phase_check.sv
module bpm_phase_check #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4,
   parameter bit TREE   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   cbe_i,
   input  logic              par_i,
   input  logic              rd_beat_i,
   input  logic              addr_phase_i,
   output logic              rd_bad_o,
   output logic              addr_bad_o
);
   localparam int SUM_W = DATA_W + BE_W;

   logic sum_odd;
   logic sum_odd_q;
   logic rd_beat_q;
   logic addr_q;
   logic mismatch;

   bpm_xor_reduce #(.W(SUM_W), .TREE(TREE)) u_reduce (
      .vec_i ({cbe_i, ad_i}),
      .odd_o (sum_odd)
   );

   // parity line trails its phase by one clock: hold the lines' sum
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sum_odd_q <= 1'b0;
         rd_beat_q <= 1'b0;
         addr_q    <= 1'b0;
      end else begin
         sum_odd_q <= sum_odd;
         rd_beat_q <= rd_beat_i;
         addr_q    <= addr_phase_i;
      end
   end

   assign mismatch   = sum_odd_q ^ par_i;
   assign rd_bad_o   = rd_beat_q & mismatch;
   assign addr_bad_o = addr_q & mismatch;
endmodule

// File: rtl/bpm_sticky_bit.sv
module bpm_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end
endmodule

// File: rtl/bus_parity_monitor.sv
module bus_parity_monitor
   import bpm_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int BE_W      = 4,
   parameter bit XOR_TREE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] ad_i,
   input  logic [BE_W-1:0]   cbe_i,
   input  logic              par_i,
   input  logic              irdy_n_i,
   input  logic              trdy_n_i,
   input  logic              mst_rd_i,
   input  logic              mst_wr_i,
   input  logic              addr_phase_i,
   input  logic              perr_n_i,
   input  logic              per_en_i,
   input  logic              serr_en_i,
   input  logic              lberr_en_i,
   input  logic              clr_we_i,
   input  logic [STAT_W-1:0] clr_mask_i,
   output logic              perr_req_o,
   output logic              serr_req_o,
   output logic              lb_err_o,
   output logic [STAT_W-1:0] status_o
);
   generate
      if (DATA_W < 8 || (DATA_W % 8) != 0) begin : g_chk_dw
         $error("bus_parity_monitor: DATA_W must be a positive multiple of 8");
      end
      if (BE_W != DATA_W / 8) begin : g_chk_be
         $error("bus_parity_monitor: BE_W must equal DATA_W/8");
      end
   endgenerate

   logic      rd_beat;
   logic      rd_bad;
   logic      addr_bad;
   logic      wr_bad;
   logic      data_err;
   stat_vec_t set_vec;
   stat_vec_t clr_vec;
   logic      perr_q, serr_q, lberr_q;

   assign rd_beat = mst_rd_i & ~irdy_n_i & ~trdy_n_i;

   bpm_phase_check #(.DATA_W(DATA_W), .BE_W(BE_W), .TREE(XOR_TREE)) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .ad_i         (ad_i),
      .cbe_i        (cbe_i),
      .par_i        (par_i),
      .rd_beat_i    (rd_beat),
      .addr_phase_i (addr_phase_i),
      .rd_bad_o     (rd_bad),
      .addr_bad_o   (addr_bad)
   );

   assign wr_bad   = mst_wr_i & ~perr_n_i;
   assign data_err = per_en_i & (rd_bad | wr_bad);

   always_comb begin
      set_vec              = '0;
      set_vec[ST_PAR_SEEN] = rd_bad;
      set_vec[ST_DPE_RPT]  = data_err;
      set_vec[ST_SERR]     = addr_bad & per_en_i & serr_en_i;
      set_vec[ST_LB_EVT]   = data_err;
   end

   assign clr_vec = clr_mask_i & {STAT_W{clr_we_i}};

   generate
      for (genvar k = 0; k < STAT_W; k++) begin : g_stat
         bpm_sticky_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_vec[k]),
            .clr_i (clr_vec[k]),
            .q_o   (status_o[k])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         perr_q  <= 1'b0;
         serr_q  <= 1'b0;
         lberr_q <= 1'b0;
      end else begin
         perr_q  <= rd_bad & per_en_i;
         serr_q  <= set_vec[ST_SERR];
         lberr_q <= data_err & lberr_en_i;
      end
   end

   assign perr_req_o = perr_q;
   assign serr_req_o = serr_q;
   assign lb_err_o   = lberr_q;
endmodule

module bus_parity_monitor_chk #(
   parameter int DATA_W = 32,
   parameter int BE_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] ad_i,
   input logic [BE_W-1:0]   cbe_i,
   input logic              par_i,
   input logic              irdy_n_i,
   input logic              trdy_n_i,
   input logic              mst_rd_i,
   input logic              mst_wr_i,
   input logic              addr_phase_i,
   input logic              perr_n_i,
   input logic              per_en_i,
   input logic              serr_en_i,
   input logic              lberr_en_i,
   input logic              clr_we_i,
   input logic [3:0]        clr_mask_i,
   input logic              perr_req_o,
   input logic              serr_req_o,
   input logic              lb_err_o,
   input logic [3:0]        status_o
);
   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // a bad read beat always raises the parity-seen flag, even against a clear (R10)
   assert_read_seen_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && $past(mst_rd_i && !irdy_n_i && !trdy_n_i)
       && (^{$past(ad_i), $past(cbe_i), par_i})) |=> status_o[0]);

   assert_only_done_beats_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && $rose(status_o[0])) |-> $past(mst_rd_i && !irdy_n_i && !trdy_n_i, 2));

   assert_reported_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && $rose(status_o[1])) |-> $past(per_en_i));

   assert_perr_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && perr_req_o) |-> $past(per_en_i));

   assert_lberr_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd1 && lb_err_o) |-> $past(per_en_i && lberr_en_i));

   assert_write_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mst_wr_i && !perr_n_i && per_en_i && lberr_en_i) |=> lb_err_o);

   assert_event_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      lb_err_o |-> status_o[3]);

   assert_serr_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc >= 2'd2 && serr_req_o) |-> (status_o[2] && $past(serr_en_i && per_en_i)
                                        && $past(addr_phase_i, 2)));

   generate
      for (genvar k = 0; k < 4; k++) begin : g_w1c
         assert_clear_only_by_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc >= 2'd1 && $fell(status_o[k])) |-> $past(clr_we_i && clr_mask_i[k]));
      end
   endgenerate
endmodule

bind bus_parity_monitor bus_parity_monitor_chk #(.DATA_W(DATA_W), .BE_W(BE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ad_i         (ad_i),
   .cbe_i        (cbe_i),
   .par_i        (par_i),
   .irdy_n_i     (irdy_n_i),
   .trdy_n_i     (trdy_n_i),
   .mst_rd_i     (mst_rd_i),
   .mst_wr_i     (mst_wr_i),
   .addr_phase_i (addr_phase_i),
   .perr_n_i     (perr_n_i),
   .per_en_i     (per_en_i),
   .serr_en_i    (serr_en_i),
   .lberr_en_i   (lberr_en_i),
   .clr_we_i     (clr_we_i),
   .clr_mask_i   (clr_mask_i),
   .perr_req_o   (perr_req_o),
   .serr_req_o   (serr_req_o),
   .lb_err_o     (lb_err_o),
   .status_o     (status_o)
);

// File: tb/bus_parity_monitor_bench.sv
module bus_parity_monitor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ad = '0;
   logic [3:0]  cbe = '0;
   logic        par = 1'b0;
   logic        irdy_n = 1'b1, trdy_n = 1'b1;
   logic        mst_rd = 1'b0, mst_wr = 1'b0, addr_ph = 1'b0;
   logic        perr_n = 1'b1;
   logic        per_en = 1'b0, serr_en = 1'b0, lberr_en = 1'b0;
   logic        clr_we = 1'b0;
   logic [3:0]  clr_mask = '0;
   logic        perr_req, serr_req, lb_err;
   logic [3:0]  status;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #10 clk = ~clk;

   bus_parity_monitor u_bus_parity_monitor (
      .clk(clk), .rst_n(rst_n), .ad_i(ad), .cbe_i(cbe), .par_i(par),
      .irdy_n_i(irdy_n), .trdy_n_i(trdy_n), .mst_rd_i(mst_rd), .mst_wr_i(mst_wr),
      .addr_phase_i(addr_ph), .perr_n_i(perr_n), .per_en_i(per_en),
      .serr_en_i(serr_en), .lberr_en_i(lberr_en), .clr_we_i(clr_we),
      .clr_mask_i(clr_mask), .perr_req_o(perr_req), .serr_req_o(serr_req),
      .lb_err_o(lb_err), .status_o(status));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk); clr_we = 1'b1; clr_mask = 4'hF;
      @(negedge clk); clr_we = 1'b0; clr_mask = 4'h0;
   endtask

   // line index 0..31 = data, 32..35 = byte enables
   function automatic logic [35:0] walk(input int b);
      logic [35:0] v = '0;
      v[b] = 1'b1;
      return v;
   endfunction

   task automatic read_beat(input logic [35:0] lines, input bit flip, input bit per,
                            input bit lbe, input bit both_ready);
      bit bad;
      clear_all();
      @(negedge clk);
      per_en = per; lberr_en = lbe; mst_rd = 1'b1;
      irdy_n = 1'b0; trdy_n = both_ready ? 1'b0 : 1'b1;
      {cbe, ad} = lines;
      bad = flip && both_ready;
      @(negedge clk);
      par = (^lines) ^ flip;
      mst_rd = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; {cbe, ad} = ~lines;
      @(negedge clk);
      par = 1'b0;
      chk("R1 R2 R3 parity seen", status[0], bad);
      chk("R4 reported", status[1], bad & per);
      chk("R7 event", status[3], bad & per);
      chk("R5 perr request", perr_req, bad & per);
      chk("R6 local error", lb_err, bad & per & lbe);
      @(negedge clk);
      chk("R6 R5 single pulse", {perr_req, lb_err}, 2'b00);
   endtask

   task automatic write_sample(input bit perr_low, input bit wr, input bit per, input bit lbe);
      bit hit;
      clear_all();
      @(negedge clk);
      per_en = per; lberr_en = lbe; mst_wr = wr; perr_n = ~perr_low;
      hit = perr_low && wr && per;
      @(negedge clk);
      chk("R6 write local error", lb_err, hit & lbe);
      chk("R4 write reported", status[1], hit);
      chk("R7 write event", status[3], hit);
      chk("R3 write leaves seen", status[0], 1'b0);
      mst_wr = 1'b0; perr_n = 1'b1;
      @(negedge clk);
      chk("R6 write pulse ends", lb_err, 1'b0);
   endtask

   task automatic addr_phase(input logic [35:0] lines, input bit flip, input bit per, input bit se);
      bit hit;
      clear_all();
      @(negedge clk);
      per_en = per; serr_en = se; addr_ph = 1'b1; {cbe, ad} = lines;
      hit = flip && per && se;
      @(negedge clk);
      addr_ph = 1'b0; par = (^lines) ^ flip; {cbe, ad} = '0;
      @(negedge clk);
      par = 1'b0;
      chk("R8 serr request", serr_req, hit);
      chk("R8 serr flag", status[2], hit);
      chk("R3 address leaves seen", status[0], 1'b0);
      @(negedge clk);
      chk("R8 serr pulse ends", serr_req, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset outputs", {perr_req, serr_req, lb_err, status}, 7'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 after release", {perr_req, serr_req, lb_err, status}, 7'd0);

      // walking one over every checked line, all enable combos
      for (int b = 0; b < 36; b++)
         for (int m = 0; m < 8; m++)
            read_beat(walk(b), m[0], m[1], m[2], 1'b1);
      read_beat(36'hF_FFFF_FFFF, 1'b0, 1'b1, 1'b1, 1'b1);
      read_beat(36'hF_FFFF_FFFF, 1'b1, 1'b1, 1'b1, 1'b1);
      read_beat(36'h5_A5A5_3C3C, 1'b1, 1'b0, 1'b1, 1'b1);
      // incomplete handshakes are never checked (R2)
      read_beat(36'h0_0000_0001, 1'b1, 1'b1, 1'b1, 1'b0);
      clear_all();
      @(negedge clk);
      per_en = 1'b1; lberr_en = 1'b1; mst_rd = 1'b1; irdy_n = 1'b1; trdy_n = 1'b0; ad = 32'h1;
      @(negedge clk);
      mst_rd = 1'b0; trdy_n = 1'b1; par = 1'b0;
      @(negedge clk);
      chk("R2 initiator not ready", {status, lb_err}, 5'd0);

      // back to back: first beat bad, second good (R2 R6)
      clear_all();
      @(negedge clk);
      per_en = 1'b1; lberr_en = 1'b1; mst_rd = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
      {cbe, ad} = 36'h0_0000_0003;
      @(negedge clk);
      par = 1'b1;
      {cbe, ad} = 36'h0_0000_0001;
      @(negedge clk);
      mst_rd = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; par = 1'b1;
      chk("R6 first beat bad", lb_err, 1'b1);
      @(negedge clk);
      par = 1'b0;
      chk("R6 second beat good", lb_err, 1'b0);

      for (int m = 0; m < 16; m++)
         write_sample(m[0], m[1], m[2], m[3]);

      for (int b = 0; b < 36; b++)
         for (int m = 0; m < 8; m++)
            addr_phase(walk(b), m[0], m[1], m[2]);

      // write-one-to-clear rules (R9)
      read_beat(36'h0_0000_0010, 1'b1, 1'b1, 1'b0, 1'b1);
      @(negedge clk);
      chk("R9 flags before clear", status, 4'b1011);
      clr_we = 1'b1; clr_mask = 4'h0;
      @(negedge clk);
      chk("R9 zero mask keeps", status, 4'b1011);
      clr_we = 1'b0; clr_mask = 4'hF;
      @(negedge clk);
      chk("R9 no strobe keeps", status, 4'b1011);
      clr_we = 1'b1; clr_mask = 4'b0001;
      @(negedge clk);
      chk("R9 single bit clear", status, 4'b1010);
      clr_mask = 4'b1010;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = 4'h0;
      chk("R9 remaining clear", status, 4'b0000);

      // set and clear on the same edge: set wins (R10)
      @(negedge clk);
      per_en = 1'b1; lberr_en = 1'b0; mst_rd = 1'b1; irdy_n = 1'b0; trdy_n = 1'b0;
      {cbe, ad} = 36'h0_0000_0100;
      @(negedge clk);
      mst_rd = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1; par = 1'b0;
      clr_we = 1'b1; clr_mask = 4'hF;
      @(negedge clk);
      clr_we = 1'b0; clr_mask = 4'h0;
      chk("R10 set beats clear", status, 4'b1011);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog R11 actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule